// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block gives a host three byte-wide parallel ports, A, B and C, and one control byte. A 2-bit register address and an 8-bit write and read bus reach all four. Each port keeps a data latch, drives an output bus toward the pins and samples an input bus from the pins. The control byte sets the directions: one bit each for ports A and B, and one bit each for the low and high halves of port C.

The control address has two uses. A write with bit 7 set replaces the whole control byte. A write with bit 7 clear leaves the control byte alone and sets or clears one bit of the port C latch instead. Any port or half-port that is configured as an input drives zeros. A read of it returns the live pin value. An output returns its latch.

The register bus is a plain synchronous strobe rather than a stream. Every write is accepted in the cycle it is presented, so there is no back-pressure and no ready signal. Reads are combinational from the address and the current state.

Top module: `pio3_top`

## Requirements
- R1: A synchronous active-high reset clears the latches of ports A, B and C to 0x00 and sets the control byte to 0x9B. All three ports are then inputs and drive 0x00. A read of address 3 returns 0x9B.
- R2: With `wr_en` high, address 0, 1 or 2 loads `wdata` into the latch of port A, B or C at the rising clock edge.
- R3: With `wr_en` high, address 3 and `wdata[7]` = 1, the whole of `wdata` is loaded into the control byte. A read of address 3 returns the control byte.
- R4: With `wr_en` high, address 3 and `wdata[7]` = 0, the control byte is unchanged. Bit `wdata[3:1]` (index 0 to 7) of the port C latch takes the value of `wdata[0]`, and no other latch bit changes.
- R5: Each direction bit, when set, marks its port or half-port as an input and forces its driven output to zero. Control bit 4 covers port A, bit 1 covers port B, bit 0 covers port C bits 3:0 and bit 3 covers port C bits 7:4. A clear direction bit makes the output carry the latch.
- R6: A read of address 0 or 1 returns `pa_in` or `pb_in` when that port is an input, and the port latch when it is an output.
- R7: A read of address 2 builds each half of port C on its own. A half that is an input returns the pin bits. A half that is an output returns the latch bits.
- R8: A data write to a port configured as an input still loads its latch, and the output shows that value once the port is switched to output.
- R9: `rdata` follows `addr` and the current state within the same cycle. In a cycle that writes an address and also reads it, `rdata` shows the value from before the edge, and the new value appears after the edge.
- R10: While `wr_en` is low, no latch and no control bit changes, whatever `addr` and `wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pa_in | input | 8 | Port A pin input |
| pb_in | input | 8 | Port B pin input |
| pc_in | input | 8 | Port C pin input |
| pa_out | output | 8 | Port A driven output |
| pb_out | output | 8 | Port B driven output |
| pc_out | output | 8 | Port C driven output |

## Verification
A write and a read of the same address can fall in the same cycle, because reads are combinational and writes land at the edge. The bench provokes this by holding a port A write on the bus and sampling `rdata` before the edge, where it must still show the old latch, and again after the edge, where it must show the new one. It also runs a long mixed sequence of data, configuration and bit set/reset writes, with the pins changing under a behavioural model. That model judges every output and the read bus on each clock, so any overlap of a write with a pin-dependent read is caught.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int PW = 8;
  localparam int CB_MODE  = 7;
  localparam int CB_A_IN  = 4;
  localparam int CB_CH_IN = 3;
  localparam int CB_B_IN  = 1;
  localparam int CB_CL_IN = 0;
  localparam logic [PW-1:0] CTRL_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pio3_regs.sv
module pio3_regs
  import pio3_pkg::*;
#(
  parameter int W = PW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_a,
  output logic [W-1:0] lat_b,
  output logic [W-1:0] lat_c,
  output logic [W-1:0] ctrl
);
  localparam int IDXW = $clog2(W);

  reg_sel_e sel;
  logic [IDXW-1:0] bit_idx;
  assign sel     = reg_sel_e'(addr);
  assign bit_idx = wdata[IDXW:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      ctrl  <= CTRL_RESET;
    end else if (wr_en) begin
      case (sel)
        SEL_A: lat_a <= wdata;
        SEL_B: lat_b <= wdata;
        SEL_C: lat_c <= wdata;
        default: begin
          if (wdata[CB_MODE]) ctrl <= wdata;
          else                lat_c[bit_idx] <= wdata[0];
        end
      endcase
    end
  end

  // R3: a full configuration write lands in the control byte
  a_r3_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3 && wdata[CB_MODE]) |=> (ctrl == $past(wdata)));

  // R4: a bit set/reset write leaves the control byte alone
  a_r4_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3 && !wdata[CB_MODE]) |=> $stable(ctrl));

  // R4: at most one port C latch bit moves, and the chosen bit holds the value
  a_r4_one_bit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3 && !wdata[CB_MODE]) |=>
      ($countones(lat_c ^ $past(lat_c)) <= 1 &&
       lat_c[$past(bit_idx)] == $past(wdata[0])));

  // R10: no strobe, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(lat_a) && $stable(lat_b) && $stable(lat_c) && $stable(ctrl)));
endmodule

// File: rtl/pio3_portmux.sv
module pio3_portmux
  import pio3_pkg::*;
#(
  parameter int W = PW
) (
  input  logic [1:0]   addr,
  input  logic [W-1:0] lat_a,
  input  logic [W-1:0] lat_b,
  input  logic [W-1:0] lat_c,
  input  logic [W-1:0] ctrl,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] rdata,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pc_out
);
  localparam int HW = W / 2;

  logic [W-1:0] rd_a, rd_b, rd_c;

  assign pa_out = ctrl[CB_A_IN] ? '0 : lat_a;
  assign pb_out = ctrl[CB_B_IN] ? '0 : lat_b;
  assign rd_a   = ctrl[CB_A_IN] ? pa_in : lat_a;
  assign rd_b   = ctrl[CB_B_IN] ? pb_in : lat_b;

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      localparam int DIRB = (h == 0) ? CB_CL_IN : CB_CH_IN;
      logic is_in;
      assign is_in = ctrl[DIRB];
      assign pc_out[h*HW +: HW] = is_in ? '0 : lat_c[h*HW +: HW];
      assign rd_c[h*HW +: HW]   = is_in ? pc_in[h*HW +: HW] : lat_c[h*HW +: HW];
    end
  endgenerate

  always_comb begin
    case (reg_sel_e'(addr))
      SEL_A:   rdata = rd_a;
      SEL_B:   rdata = rd_b;
      SEL_C:   rdata = rd_c;
      default: rdata = ctrl;
    endcase
  end
endmodule

// File: rtl/pio3_top.sv
module pio3_top
  import pio3_pkg::*;
#(
  parameter int W = PW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  input  logic [W-1:0] pb_in,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pc_out
);
  logic [W-1:0] lat_a, lat_b, lat_c, ctrl;

  pio3_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c), .ctrl(ctrl)
  );

  pio3_portmux #(.W(W)) u_mux (
    .addr(addr), .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c), .ctrl(ctrl),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .rdata(rdata), .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out)
  );

  // R5: input ports drive zero
  a_r5_a_quiet: assert property (@(posedge clk) disable iff (rst)
    ctrl[CB_A_IN] |-> (pa_out == '0));
  a_r5_b_quiet: assert property (@(posedge clk) disable iff (rst)
    ctrl[CB_B_IN] |-> (pb_out == '0));

  // R6: reading an input port shows the pins
  a_r6_a_pins: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd0 && ctrl[CB_A_IN]) |-> (rdata == pa_in));

  // R2: a data write to port B shows up on the read path one edge later
  a_r2_b_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1) |=> (ctrl[CB_B_IN] || addr != 2'd1 || rdata == $past(wdata)));
endmodule

// File: tb/pio3_top_bench.sv
module pio3_top_bench;
  logic clk = 0;
  logic rst = 1;
  logic wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] rdata, pa_out, pb_out, pc_out;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural reference state
  byte unsigned m_a, m_b, m_c, m_ctl;

  always #10 clk = ~clk;

  pio3_top u_pio3_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic byte unsigned exp_pa();
    return m_ctl[4] ? 8'h00 : m_a;
  endfunction
  function automatic byte unsigned exp_pb();
    return m_ctl[1] ? 8'h00 : m_b;
  endfunction
  function automatic byte unsigned exp_pc();
    byte unsigned v = m_c;
    if (m_ctl[0]) v = v & 8'hF0;
    if (m_ctl[3]) v = v & 8'h0F;
    return v;
  endfunction
  function automatic byte unsigned exp_rd(logic [1:0] a);
    byte unsigned v;
    case (a)
      2'd0: v = m_ctl[4] ? pa_in : m_a;
      2'd1: v = m_ctl[1] ? pb_in : m_b;
      2'd2: begin
        v = m_c;
        if (m_ctl[0]) v = (v & 8'hF0) | (pc_in & 8'h0F);
        if (m_ctl[3]) v = (v & 8'h0F) | (pc_in & 8'hF0);
      end
      default: v = m_ctl;
    endcase
    return v;
  endfunction

  // model update at each edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_a = 0; m_b = 0; m_c = 0; m_ctl = 8'h9B;
    end else if (wr_en) begin
      case (addr)
        2'd0: m_a = wdata;
        2'd1: m_b = wdata;
        2'd2: m_c = wdata;
        default:
          if (wdata[7]) m_ctl = wdata;
          else m_c[wdata[3:1]] = wdata[0];
      endcase
    end
  end

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #5;
    if (!rst) begin
      chk("R5 pa_out", pa_out, exp_pa());
      chk("R5 pb_out", pb_out, exp_pb());
      chk("R5 pc_out", pc_out, exp_pc());
      case (addr)
        2'd0, 2'd1: chk("R6 rdata", rdata, exp_rd(addr));
        2'd2:       chk("R7 rdata", rdata, exp_rd(addr));
        default:    chk("R3 rdata", rdata, exp_rd(addr));
      endcase
    end
  end

  // watchdog
  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  logic [7:0] v;
  logic [7:0] lf;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    rd(2'd3, v); chk("R1 ctrl", v, 8'h9B);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    pa_in = 8'h5A;
    rd(2'd0, v); chk("R6 A input pins", v, 8'h5A);

    // R8 write while input
    wr(2'd0, 8'h3C);
    chk("R8 A held at zero", pa_out, 8'h00);
    wr(2'd3, 8'h80);
    chk("R8 A shows latch", pa_out, 8'h3C);
    rd(2'd0, v); chk("R6 A output latch", v, 8'h3C);
    rd(2'd3, v); chk("R3 ctrl load", v, 8'h80);

    // R2 data writes
    wr(2'd1, 8'hA5); chk("R2 B", pb_out, 8'hA5);
    wr(2'd2, 8'h0F); chk("R2 C", pc_out, 8'h0F);

    // R4 bit set / clear
    wr(2'd3, 8'h0D); chk("R4 set bit6", pc_out, 8'h4F);
    wr(2'd3, 8'h00); chk("R4 clear bit0", pc_out, 8'h4E);
    wr(2'd3, 8'h0F); chk("R4 set bit7", pc_out, 8'hCE);
    rd(2'd3, v); chk("R4 ctrl kept", v, 8'h80);

    // R7 split nibbles
    pc_in = 8'h93;
    wr(2'd3, 8'h81);
    chk("R5 C low forced", pc_out, 8'hC0);
    rd(2'd2, v); chk("R7 C low pins", v, 8'hC3);
    wr(2'd3, 8'h88);
    chk("R5 C high forced", pc_out, 8'h0E);
    rd(2'd2, v); chk("R7 C high pins", v, 8'h9E);
    wr(2'd3, 8'h92);
    chk("R5 A forced", pa_out, 8'h00);
    chk("R5 B forced", pb_out, 8'h00);
    pb_in = 8'h66;
    rd(2'd1, v); chk("R6 B pins", v, 8'h66);
    wr(2'd3, 8'h80);

    // R10 no strobe
    @(negedge clk);
    addr = 2'd0; wdata = 8'hFF;
    @(negedge clk);
    addr = 2'd3; wdata = 8'h9B;
    @(negedge clk);
    #1;
    chk("R10 A unchanged", pa_out, 8'h3C);
    rd(2'd3, v); chk("R10 ctrl unchanged", v, 8'h80);

    // R9 same-cycle write and read of port A
    @(negedge clk);
    wr_en = 1; addr = 2'd0; wdata = 8'h77;
    #1;
    chk("R9 old value before edge", rdata, 8'h3C);
    @(negedge clk);
    wr_en = 0;
    #1;
    chk("R9 new value after edge", rdata, 8'h77);

    // mixed deterministic sequence under the per-cycle model
    lf = 8'hB7;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      pa_in = lf ^ 8'h11;
      pb_in = ~lf;
      pc_in = {lf[3:0], lf[7:4]};
      if (lf[1:0] == 2'd3 && lf[2]) wr(2'd3, {1'b1, lf[6:0]});
      else wr(lf[1:0], {lf[4:0], lf[7:5]});
      rd(lf[3:2], v);
      chk("R7 mixed read", v, exp_rd(lf[3:2]));
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule